// File: doc/BRIEF.md
# Delayed Lockstep Output Comparator

This block watches a redundant pair of identical execution units that perform the same work. The second unit, the checker, runs a fixed number of clock cycles behind the first, the main unit. The default lag is two cycles. Because of the stagger, one transient event cannot corrupt both copies in the same way at the same moment. The block produces the checker's inputs by passing the main unit's inputs through a delay line. It passes the main unit's output bus through a delay line of the same depth. Each main result therefore meets the checker result for the same step. The comparison runs on every cycle and needs no software action.

Any difference on any output bit sets a sticky fault flag. The flag stays set until a dedicated clear input or reset removes it. Just after reset the delay lines still hold reset data rather than real work, so the comparison stays blocked until they are filled.

A self-test input flips one chosen bit of the checker path on its way into the comparator. Software or a test sequencer can use it to prove that the detection path can still raise the fault.

Top module: `lockstep_cmp`

## Requirements
- R1: `chk_in` equals the value `main_in` had at the clock edge two cycles earlier.
- R2: The block delays `main_out` by two cycles and compares it bit for bit with `chk_out`. When the two agree and self-test is off, `fault` does not rise.
- R3: When the delayed `main_out` and `chk_out` differ in any bit during an armed cycle, `fault` is 1 after the next clock edge.
- R4: The comparison is ignored on the first two clock edges after reset is released. A difference on those edges leaves `fault` at 0.
- R5: `fault` is sticky. Once set, it stays 1 while `fault_clr` is low, even after the outputs agree again.
- R6: `fault_clr` high, with no difference present in that cycle, returns `fault` to 0 at the next edge.
- R7: A difference in the same cycle as `fault_clr` wins: `fault` is 1 after that edge.
- R8: While `selftest_en` is 1, bit `INJ_BIT` (bit 0 by default) of `chk_out` is inverted before the comparison. Matching outputs then raise `fault`. A checker output that is already wrong in exactly that bit is seen as a match.
- R9: While `rst_n` is low (active-low, synchronous), `fault` is 0 and `chk_in` is all zeros at each edge.
- R10: A reset in mid-operation restarts the two-edge ignore window of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| main_in | input | IN_W | Inputs applied to the main unit |
| main_out | input | OUT_W | Output bus of the main unit |
| chk_out | input | OUT_W | Output bus of the checker unit |
| fault_clr | input | 1 | Clears the sticky fault flag |
| selftest_en | input | 1 | Flips bit INJ_BIT of the checker path before the comparison |
| chk_in | output | IN_W | Delayed inputs to drive the checker unit |
| fault | output | 1 | Sticky lockstep mismatch flag |

## Verification
The assertions assume that the external checker unit responds to `chk_in` in the same cycle, exactly as the main unit responds to `main_in`. Under that assumption, a checker output equal to the main output from two cycles earlier counts as a correct pair. In the bench both units are the same combinational function, so every pair agrees unless the bench deliberately XORs an error mask into `chk_out`. The mask is usually zero. When it is nonzero it usually holds a single bit, so each disagreement the assertions see comes from a known, intended corruption or from self-test.

// File: rtl/lockstep_pkg.sv
// Package lockstep_pkg
// Holds the defaults and helper functions shared by the lockstep comparator
// modules. Assumes nothing beyond elaboration-time constant evaluation.
package lockstep_pkg;

    // Default lag, in cycles, between the main and the checker unit.
    localparam int unsigned LS_DEFAULT_DELAY = 2;

    // Number of bits needed to hold a count from 0 to n inclusive.
    function automatic int unsigned ls_cnt_width(input int unsigned n);
        int unsigned w;
        w = 1;
        while ((1 << w) <= n) begin
            w = w + 1;
        end
        return w;
    endfunction

endpackage

// File: rtl/ls_delay_line.sv
// Module ls_delay_line
// Fixed-depth register pipeline. The output equals the input sampled DEPTH
// edges earlier. Every stage resets to zero. Assumes DEPTH >= 1.
module ls_delay_line #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            // Purpose: capture the incoming word into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[0] <= '0;
                else        stage[0] <= d;
            end
        end else begin : g_body
            // Purpose: shift the word one stage further down the line.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    assign q = stage[DEPTH-1];

endmodule

// File: rtl/ls_fill_tracker.sv
// Module ls_fill_tracker
// Counts the edges since reset was released, saturating at DEPTH. It reports
// "armed" once both delay lines hold real data. Assumes the delay lines share
// this reset and depth.
module ls_fill_tracker
    import lockstep_pkg::*;
#(
    parameter int unsigned DEPTH = LS_DEFAULT_DELAY
) (
    input  logic clk,
    input  logic rst_n,
    output logic armed
);

    localparam int unsigned CW = ls_cnt_width(DEPTH);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [CW-1:0] fill_cnt;

    // Purpose: count filled stages after reset and hold at full.
    always_ff @(posedge clk) begin
        if (!rst_n)                fill_cnt <= '0;
        else if (fill_cnt != FULL) fill_cnt <= fill_cnt + 1'b1;
    end

    assign armed = (fill_cnt == FULL);

endmodule

// File: rtl/ls_out_compare.sv
// Module ls_out_compare
// Compares the delayed main output with the checker output. When inject is
// set it first flips bit INJ_BIT of the checker output. The result is
// qualified by armed. Purely combinational. Assumes INJ_BIT < W.
module ls_out_compare #(
    parameter int unsigned W       = 16,
    parameter int unsigned INJ_BIT = 0
) (
    input  logic [W-1:0] main_dly,
    input  logic [W-1:0] chk_out,
    input  logic         inject,
    input  logic         armed,
    output logic         hit
);

    localparam logic [W-1:0] INJ_MASK = W'(1) << INJ_BIT;

    logic [W-1:0] chk_view;

    // Purpose: form the checker word as seen by the comparator, with injection.
    always_comb begin
        chk_view = inject ? (chk_out ^ INJ_MASK) : chk_out;
    end

    // Purpose: flag any bit difference once the pipelines are filled.
    always_comb begin
        hit = armed && (chk_view != main_dly);
    end

endmodule

// File: rtl/ls_fault_latch.sv
// Module ls_fault_latch
// Sticky fault register. A new hit takes priority over a clear in the same
// cycle, so no fault is lost. Assumes hit is already qualified.
module ls_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic fault
);

    // Purpose: set on hit, hold until cleared, with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   fault <= 1'b0;
        else if (hit) fault <= 1'b1;
        else if (clr) fault <= 1'b0;
    end

endmodule

// File: rtl/lockstep_cmp.sv
// Module lockstep_cmp
// Top of the delayed lockstep comparator. It delays the main unit's inputs to
// produce the checker's inputs and delays the main unit's outputs by the same
// depth. It compares them with the checker's outputs and keeps a sticky fault
// flag. Assumes the checker unit answers chk_in in the same cycle, as the main
// unit answers main_in.
module lockstep_cmp
    import lockstep_pkg::*;
#(
    parameter int unsigned IN_W    = 16,
    parameter int unsigned OUT_W   = 16,
    parameter int unsigned DELAY   = LS_DEFAULT_DELAY,
    parameter int unsigned INJ_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  main_in,
    input  logic [OUT_W-1:0] main_out,
    input  logic [OUT_W-1:0] chk_out,
    input  logic             fault_clr,
    input  logic             selftest_en,
    output logic [IN_W-1:0]  chk_in,
    output logic             fault
);

    logic [OUT_W-1:0] main_out_dly;
    logic             cmp_armed;
    logic             cmp_hit;

    // Input side: staggers the checker unit behind the main unit.
    ls_delay_line #(.W(IN_W), .DEPTH(DELAY)) in_dly_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (main_in),
        .q     (chk_in)
    );

    // Output side: aligns each main result with the checker result for the same step.
    ls_delay_line #(.W(OUT_W), .DEPTH(DELAY)) out_dly_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (main_out),
        .q     (main_out_dly)
    );

    // Blocks the comparison until both lines carry real data.
    ls_fill_tracker #(.DEPTH(DELAY)) fill_i (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (cmp_armed)
    );

    ls_out_compare #(.W(OUT_W), .INJ_BIT(INJ_BIT)) cmp_i (
        .main_dly (main_out_dly),
        .chk_out  (chk_out),
        .inject   (selftest_en),
        .armed    (cmp_armed),
        .hit      (cmp_hit)
    );

    ls_fault_latch flag_i (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (cmp_hit),
        .clr   (fault_clr),
        .fault (fault)
    );

endmodule

// File: rtl/lockstep_cmp_chk.sv
// Module lockstep_cmp_chk
// Assertion checker bound to lockstep_cmp. Written for the default two-cycle
// lag. Its own saturating counter gives the number of edges since reset, so
// that no $past reaches back before reset.
module lockstep_cmp_chk #(
    parameter int unsigned IN_W  = 16,
    parameter int unsigned OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IN_W-1:0]  main_in,
    input logic [OUT_W-1:0] main_out,
    input logic [OUT_W-1:0] chk_out,
    input logic             fault_clr,
    input logic             selftest_en,
    input logic [IN_W-1:0]  chk_in,
    input logic             fault,
    input logic             hit
);

    logic [1:0] since_rst;

    // Purpose: count edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: checker inputs are the main inputs from two edges back
    a_r1_input_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (chk_in == $past(main_in, 2)));

    // R2: agreeing outputs without self-test never raise a clear flag
    a_r2_quiet_match: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && !selftest_en && !fault && chk_out == $past(main_out, 2))
        |=> !fault);

    // R3 and R7: a qualified difference sets the flag, even with a clear
    a_r3_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> fault);

    // R4: no flag is raised during the fill window
    a_r4_fill_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 2'd2 && !fault) |=> !fault);

    // R5: the flag holds while no clear is requested
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !fault_clr) |=> fault);

    // R6: a clear without a difference drops the flag
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_clr && !hit) |=> !fault);

    // R8: self-test on matching outputs forces a fault
    a_r8_inject: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && selftest_en && chk_out == $past(main_out, 2)) |=> fault);

endmodule

bind lockstep_cmp lockstep_cmp_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .main_in     (main_in),
    .main_out    (main_out),
    .chk_out     (chk_out),
    .fault_clr   (fault_clr),
    .selftest_en (selftest_en),
    .chk_in      (chk_in),
    .fault       (fault),
    .hit         (cmp_hit)
);

// File: tb/lockstep_cmp_tb_top.sv
// Bench for lockstep_cmp. Both units are the same combinational function.
// The bench corrupts the checker output with an error mask when it chooses
// to. Expected values come from a cycle model held in the bench.
module lockstep_cmp_tb_top;

    localparam int unsigned IN_W    = 16;
    localparam int unsigned OUT_W   = 16;
    localparam int unsigned INJ_BIT = 0;
    localparam logic [OUT_W-1:0] INJ_MASK = OUT_W'(1) << INJ_BIT;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [IN_W-1:0]  main_in;
    logic [OUT_W-1:0] main_out;
    logic [OUT_W-1:0] chk_out;
    logic [OUT_W-1:0] err_mask;
    logic             fault_clr;
    logic             selftest_en;
    logic [IN_W-1:0]  chk_in;
    logic             fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state: value after the most recent modelled edge.
    logic [IN_W-1:0] m_s1 = '0;
    logic [IN_W-1:0] m_s2 = '0;
    int              m_fill = 0;
    logic            m_fault = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [OUT_W-1:0] unit_fn(input logic [IN_W-1:0] x);
        return OUT_W'(x * 16'd5 + 16'd3) ^ {x[7:0], x[15:8]};
    endfunction

    assign main_out = unit_fn(main_in);
    assign chk_out  = unit_fn(chk_in) ^ err_mask;

    lockstep_cmp #(.IN_W(IN_W), .OUT_W(OUT_W), .DELAY(2), .INJ_BIT(INJ_BIT)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .main_in     (main_in),
        .main_out    (main_out),
        .chk_out     (chk_out),
        .fault_clr   (fault_clr),
        .selftest_en (selftest_en),
        .chk_in      (chk_in),
        .fault       (fault)
    );

    function automatic bit flag_hit(input int fill, input logic [OUT_W-1:0] err, input logic st);
        return (fill >= 2) && ((err ^ (st ? INJ_MASK : '0)) != '0);
    endfunction

    // One cycle: drive at negedge, advance the model, check at the next negedge.
    task automatic step(input logic rn, input logic [IN_W-1:0] din, input logic [OUT_W-1:0] err,
                        input logic clr, input logic st, input string tag);
        rst_n = rn; main_in = din; err_mask = err; fault_clr = clr; selftest_en = st;
        if (!rn) begin
            m_fault = 1'b0; m_s1 = '0; m_s2 = '0; m_fill = 0;
        end else begin
            m_fault = flag_hit(m_fill, err, st) || (m_fault && !clr);
            m_s2 = m_s1; m_s1 = din;
            if (m_fill < 3) m_fill = m_fill + 1;
        end
        @(negedge clk);
        checks++;
        if (fault !== m_fault) begin
            fails++;
            $display("FAIL %s: fault actual=%0b expected=%0b", tag, fault, m_fault);
        end
        checks++;
        if (chk_in !== m_s2) begin
            fails++;
            $display("FAIL %s: chk_in actual=%h expected=%h", rn ? "R1" : "R9", chk_in, m_s2);
        end
    endtask

    function automatic logic [OUT_W-1:0] one_bit();
        return OUT_W'(1) << ($urandom % OUT_W);
    endfunction

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        rst_n = 1'b0; main_in = '0; err_mask = '0; fault_clr = 1'b0; selftest_en = 1'b0;
        @(negedge clk);
        // R9: reset state with busy inputs
        step(1'b0, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, "R9");
        step(1'b0, 16'h1234, 16'h0001, 1'b0, 1'b0, "R9");
        // R4: differences on the first two edges are ignored
        step(1'b1, 16'hA5A5, 16'h8000, 1'b0, 1'b0, "R4");
        step(1'b1, 16'h0F0F, 16'h0001, 1'b0, 1'b1, "R4");
        // R2: clean matching traffic
        for (int i = 0; i < 20; i++) step(1'b1, 16'($urandom), '0, 1'b0, 1'b0, "R2");
        // R3: single-bit difference on the top bit, then R5 sticky hold
        step(1'b1, 16'h1111, 16'h8000, 1'b0, 1'b0, "R3");
        for (int i = 0; i < 5; i++) step(1'b1, 16'($urandom), '0, 1'b0, 1'b0, "R5");
        // R6: clear with no difference
        step(1'b1, 16'h2222, '0, 1'b1, 1'b0, "R6");
        step(1'b1, 16'h3333, '0, 1'b0, 1'b0, "R6");
        // R7: clear and difference together
        step(1'b1, 16'h4444, 16'h0100, 1'b1, 1'b0, "R7");
        step(1'b1, 16'h5555, '0, 1'b1, 1'b0, "R6");
        // R8: self-test raises a fault on matching outputs
        step(1'b1, 16'h6666, '0, 1'b0, 1'b1, "R8");
        step(1'b1, 16'h7777, '0, 1'b1, 1'b0, "R6");
        // R8: an error in exactly the injected bit cancels the injection
        step(1'b1, 16'h8888, INJ_MASK, 1'b0, 1'b1, "R8");
        step(1'b1, 16'h9999, INJ_MASK | 16'h0004, 1'b0, 1'b1, "R8");
        step(1'b1, 16'hAAAA, '0, 1'b1, 1'b0, "R6");
        // R10: reset in mid-run restarts the ignore window
        step(1'b0, 16'hBBBB, '0, 1'b0, 1'b0, "R9");
        step(1'b1, 16'hCCCC, 16'h0002, 1'b0, 1'b0, "R10");
        step(1'b1, 16'hDDDD, 16'h0040, 1'b0, 1'b0, "R10");
        step(1'b1, 16'hEEEE, 16'h0040, 1'b0, 1'b0, "R10");
        step(1'b1, 16'h0001, '0, 1'b1, 1'b0, "R6");
        // Random mix of all behaviours
        for (int i = 0; i < 600; i++) begin
            logic [OUT_W-1:0] e;
            e = (($urandom % 16) == 0) ? one_bit() : '0;
            step(1'b1, 16'($urandom), e, (($urandom % 4) == 0), (($urandom % 32) == 0), "R3");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule